// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This execution unit multiplies two 32-bit register operands and folds the signed product into one of four 48-bit accumulators, either adding or subtracting it. In the same operation the product can also update a second accumulator, with its own add or subtract choice. Operands are either full 32-bit values (long mode) or 16-bit halves picked from each register (word mode). A two-bit scale code doubles or halves the product before it is accumulated.

Besides the arithmetic, the unit moves data between the accumulators and a 32-bit data port. It also moves data between an accumulator and another accumulator, and between the per-pair extension registers and the port. All controls arrive already decoded. A command is taken on a clock edge where the start strobe is high. Its effects and a one-cycle done pulse appear right after that edge.

Each accumulator is 48 bits wide. The low 32 bits are the accumulator word. The top 16 bits live in the extension register of its pair. Accumulators 0 and 1 share one extension register and accumulators 2 and 3 share the other. In that 32-bit extension register, the even accumulator owns bits 15:0 and the odd accumulator owns bits 31:16.

Top module: `mac_dual_unit`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, both extension registers, the overflow flag, `dout` and `done` to zero.
- R2: With `cmd`=0 (multiply-accumulate) and `long_mode`=1, the signed 32x32 product of `opx` and `opy` is added to accumulator `acc_pri` when `subtract`=0, and subtracted from it when `subtract`=1.
- R3: With `long_mode`=0, each operand is a 16-bit half of its register. `x_upper`=1 selects `opx[31:16]` and 0 selects `opx[15:0]`; `y_upper` selects the half of `opy` in the same way.
- R4: In word mode, both halves and their 32-bit product are treated as signed and sign-extended before any accumulator is updated.
- R5: The scale code shifts the product before accumulation. Code 0 leaves it unshifted, 1 shifts it left by one, 3 shifts it arithmetically right by one, and 2 leaves it unshifted.
- R6: `dual_mode`=1 adds the scaled product to accumulator `acc_sec` and `dual_mode`=3 subtracts it from that accumulator, whatever `subtract` is. Codes 0 and 2 leave `acc_sec` alone. The secondary update uses the value `acc_sec` held before the operation.
- R7: When a dual update names the same accumulator as the primary update, only the dual update's result is stored.
- R8: Accumulator updates wrap modulo 2^48. The overflow flag `ovf` is set when the exact signed result of any update computed in the operation falls outside the signed 48-bit range, and stays set afterwards. A status write (`cmd`=6) loads `ovf` from `din[0]`.
- R9: `cmd`=1 puts bits 31:0 of accumulator `acc_pri` on `dout`. `cmd`=2 writes `din` into bits 31:0 of accumulator `acc_pri` and keeps its top 16 bits. `cmd`=3 copies all 48 bits of accumulator `acc_pri` into accumulator `acc_sec`.
- R10: `cmd`=4 puts the extension register of the pair holding `acc_pri` on `dout`, with the odd accumulator's bits 47:32 in 31:16 and the even accumulator's bits 47:32 in 15:0. `cmd`=5 writes `din` into that extension register using the same layout.
- R11: `done` is high for exactly the cycle after each edge where `start` is high. `dout` changes only on commands 1 and 4. When `start` is low, or `cmd`=7, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the command on this edge |
| cmd | input | 3 | Command: 0 MAC, 1 acc read, 2 acc write, 3 acc copy, 4 ext read, 5 ext write, 6 status write, 7 no-op |
| opx | input | 32 | First operand register value |
| opy | input | 32 | Second operand register value |
| long_mode | input | 1 | 1: 32-bit operands, 0: 16-bit halves |
| x_upper | input | 1 | Word mode: take the upper half of `opx` |
| y_upper | input | 1 | Word mode: take the upper half of `opy` |
| scale | input | 2 | Product scale code |
| subtract | input | 1 | Primary update: 0 add, 1 subtract |
| dual_mode | input | 2 | Secondary update: 1 add, 3 subtract, else none |
| acc_pri | input | 2 | Primary / source accumulator index |
| acc_sec | input | 2 | Secondary / copy destination index |
| din | input | 32 | Data port input |
| dout | output | 32 | Data port output, registered |
| done | output | 1 | Completion pulse |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is an overflowing update combined with a same-target dual update. An accumulator only nears the 48-bit limit once its extension bits are loaded. The stimulus therefore writes the extension register and the low word directly to place accumulator 0 at the largest positive value. It then issues small multiply-accumulates that cross the limit, first alone and then with both updates aimed at the same accumulator and opposite signs. This separates "secondary result wins" from "primary result wins" and shows the sticky flag surviving the commands that follow. A long run of arbitrary commands then compares every cycle against a behavioural model.

// File: rtl/mac_pkg.sv
package mac_pkg;
    parameter int DATA_W  = 32;
    parameter int EXT_W   = 16;
    parameter int NUM_ACC = 4;

    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = DATA_W + EXT_W;
    localparam int IDX_W  = $clog2(NUM_ACC);
    localparam int PROD_W = 2 * DATA_W + 2;

    typedef enum logic [2:0] {
        CMD_MAC     = 3'd0,
        CMD_ACC_RD  = 3'd1,
        CMD_ACC_WR  = 3'd2,
        CMD_ACC_CP  = 3'd3,
        CMD_EXT_RD  = 3'd4,
        CMD_EXT_WR  = 3'd5,
        CMD_STAT_WR = 3'd6,
        CMD_NOP     = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        SC_NONE  = 2'd0,
        SC_LEFT  = 2'd1,
        SC_RSVD  = 2'd2,
        SC_RIGHT = 2'd3
    } scale_e;

    typedef struct packed {
        logic   long_mode;
        logic   x_upper;
        logic   y_upper;
        scale_e scale;
    } mul_ctl_t;

    typedef struct packed {
        logic             en;
        logic             sub;
        logic [IDX_W-1:0] idx;
    } upd_ctl_t;

    function automatic logic dual_enabled(input logic [1:0] mode);
        return mode[0];
    endfunction

    function automatic logic dual_subtracts(input logic [1:0] mode);
        return mode[1];
    endfunction
endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
(
    input  mul_ctl_t                 ctl,
    input  logic [DATA_W-1:0]        opx,
    input  logic [DATA_W-1:0]        opy,
    output logic signed [PROD_W-1:0] prod_o
);
    logic [DATA_W-1:0]        src    [2];
    logic                     sel_up [2];
    logic signed [PROD_W-1:0] op_ext [2];
    logic signed [PROD_W-1:0] raw;

    assign src[0]    = opx;
    assign src[1]    = opy;
    assign sel_up[0] = ctl.x_upper;
    assign sel_up[1] = ctl.y_upper;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [HALF_W-1:0] half;
        always_comb begin
            half = sel_up[g] ? src[g][DATA_W-1:HALF_W] : src[g][HALF_W-1:0];
            if (ctl.long_mode)
                op_ext[g] = {{(PROD_W-DATA_W){src[g][DATA_W-1]}}, src[g]};
            else
                op_ext[g] = {{(PROD_W-HALF_W){half[HALF_W-1]}}, half};
        end
    end

    assign raw = op_ext[0] * op_ext[1];

    always_comb begin
        unique case (ctl.scale)
            SC_LEFT:  prod_o = raw <<< 1;
            SC_RIGHT: prod_o = raw >>> 1;
            default:  prod_o = raw;
        endcase
    end
endmodule

// File: rtl/mac_acc_adder.sv
module mac_acc_adder
    import mac_pkg::*;
(
    input  logic [ACC_W-1:0]         acc_i,
    input  logic signed [PROD_W-1:0] term_i,
    input  logic                     sub_i,
    output logic [ACC_W-1:0]         acc_o,
    output logic                     ovf_o
);
    logic signed [PROD_W-1:0] base;
    logic signed [PROD_W-1:0] total;
    logic [PROD_W-ACC_W:0]    top;

    always_comb begin
        base  = {{(PROD_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
        total = sub_i ? (base - term_i) : (base + term_i);
        acc_o = total[ACC_W-1:0];
        top   = total[PROD_W-1:ACC_W-1];
        ovf_o = !((&top) || !(|top));
    end
endmodule

// File: rtl/mac_dual_unit.sv
module mac_dual_unit
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [DATA_W-1:0] opx,
    input  logic [DATA_W-1:0] opy,
    input  logic              long_mode,
    input  logic              x_upper,
    input  logic              y_upper,
    input  logic [1:0]        scale,
    input  logic              subtract,
    input  logic [1:0]        dual_mode,
    input  logic [IDX_W-1:0]  acc_pri,
    input  logic [IDX_W-1:0]  acc_sec,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              done,
    output logic              ovf
);
    logic [ACC_W-1:0]         acc_q [NUM_ACC];
    cmd_e                     cmd_c;
    mul_ctl_t                 mctl;
    upd_ctl_t                 upd   [2];
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         upd_val [2];
    logic                     upd_ovf [2];
    logic [IDX_W-1:0]         even_idx, odd_idx;
    logic                     any_ovf;

    assign cmd_c = cmd_e'(cmd);
    assign mctl  = '{long_mode: long_mode, x_upper: x_upper,
                     y_upper: y_upper, scale: scale_e'(scale)};

    assign upd[0] = '{en: 1'b1, sub: subtract, idx: acc_pri};
    assign upd[1] = '{en: dual_enabled(dual_mode),
                      sub: dual_subtracts(dual_mode), idx: acc_sec};

    assign even_idx = {acc_pri[IDX_W-1:1], 1'b0};
    assign odd_idx  = {acc_pri[IDX_W-1:1], 1'b1};

    mac_product u_prod (
        .ctl    (mctl),
        .opx    (opx),
        .opy    (opy),
        .prod_o (prod)
    );

    for (genvar u = 0; u < 2; u++) begin : g_upd
        mac_acc_adder u_add (
            .acc_i  (acc_q[upd[u].idx]),
            .term_i (prod),
            .sub_i  (upd[u].sub),
            .acc_o  (upd_val[u]),
            .ovf_o  (upd_ovf[u])
        );
    end

    assign any_ovf = upd_ovf[0] || (upd[1].en && upd_ovf[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
            dout <= '0;
            done <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                unique case (cmd_c)
                    CMD_MAC: begin
                        acc_q[upd[0].idx] <= upd_val[0];
                        if (upd[1].en) acc_q[upd[1].idx] <= upd_val[1];
                        if (any_ovf) ovf <= 1'b1;
                    end
                    CMD_ACC_RD:  dout <= acc_q[acc_pri][DATA_W-1:0];
                    CMD_ACC_WR:  acc_q[acc_pri][DATA_W-1:0] <= din;
                    CMD_ACC_CP:  acc_q[acc_sec] <= acc_q[acc_pri];
                    CMD_EXT_RD:  dout <= {acc_q[odd_idx][ACC_W-1:DATA_W],
                                          acc_q[even_idx][ACC_W-1:DATA_W]};
                    CMD_EXT_WR: begin
                        acc_q[even_idx][ACC_W-1:DATA_W] <= din[EXT_W-1:0];
                        acc_q[odd_idx][ACC_W-1:DATA_W]  <= din[2*EXT_W-1:EXT_W];
                    end
                    CMD_STAT_WR: ovf <= din[0];
                    default: ;
                endcase
            end
        end
    end

    // R1: reset leaves outputs cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && !ovf && dout == '0));

    // R11: done is exactly one cycle behind start
    a_r11_done_follows: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r11_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R11: dout moves only on the two read commands
    a_r11_dout_holds: assert property (@(posedge clk) disable iff (rst)
        !(start && (cmd_c == CMD_ACC_RD || cmd_c == CMD_EXT_RD)) |=> $stable(dout));

    // R8: overflow flag is sticky until a status write
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(start && cmd_c == CMD_STAT_WR)) |=> ovf);

    // R8: flag only rises as a result of an accepted command
    a_r8_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(start));
endmodule

// File: tb/sim_mac_dual_unit.sv
module sim_mac_dual_unit;
    localparam logic [2:0] K_MAC = 3'd0, K_RD = 3'd1, K_WR = 3'd2, K_CP = 3'd3,
                           K_XRD = 3'd4, K_XWR = 3'd5, K_ST = 3'd6, K_NOP = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cmd = '0;
    logic [31:0] opx = '0, opy = '0, din = '0;
    logic        long_mode = 1'b1, x_upper = 1'b0, y_upper = 1'b0, subtract = 1'b0;
    logic [1:0]  scale = '0, dual_mode = '0, acc_pri = '0, acc_sec = '0;
    logic [31:0] dout;
    logic        done, ovf;

    logic [47:0] m_acc [4];
    logic [31:0] m_dout;
    logic        m_done, m_ovf;
    int          n_cmp = 0, n_bad = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    mac_dual_unit u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .opx(opx), .opy(opy),
        .long_mode(long_mode), .x_upper(x_upper), .y_upper(y_upper),
        .scale(scale), .subtract(subtract), .dual_mode(dual_mode),
        .acc_pri(acc_pri), .acc_sec(acc_sec), .din(din),
        .dout(dout), .done(done), .ovf(ovf)
    );

    function automatic logic signed [79:0] ref_prod();
        logic signed [79:0] a, b, p;
        logic [15:0] hx, hy;
        hx = x_upper ? opx[31:16] : opx[15:0];
        hy = y_upper ? opy[31:16] : opy[15:0];
        if (long_mode) begin a = $signed(opx); b = $signed(opy); end
        else begin a = $signed(hx); b = $signed(hy); end
        p = a * b;
        if (scale == 2'd1) p = p * 2;
        else if (scale == 2'd3) p = p >>> 1;
        return p;
    endfunction

    function automatic logic [47:0] ref_apply(input logic [47:0] acc,
            input logic signed [79:0] p, input logic neg, inout logic flag);
        logic signed [79:0] av, s;
        av = $signed(acc);
        s  = neg ? av - p : av + p;
        if (s > 80'sd140737488355327 || s < -80'sd140737488355328) flag = 1'b1;
        return s[47:0];
    endfunction

    task automatic model_step();
        logic [47:0] pre [4];
        logic signed [79:0] p;
        logic [47:0] r0, r1;
        logic f;
        for (int i = 0; i < 4; i++) pre[i] = m_acc[i];
        m_done = start;
        if (!start) return;
        case (cmd)
            K_MAC: begin
                p = ref_prod();
                f = m_ovf;
                r0 = ref_apply(pre[acc_pri], p, subtract, f);
                m_acc[acc_pri] = r0;
                if (dual_mode == 2'd1 || dual_mode == 2'd3) begin
                    r1 = ref_apply(pre[acc_sec], p, dual_mode == 2'd3, f);
                    m_acc[acc_sec] = r1;
                end
                m_ovf = f;
            end
            K_RD:  m_dout = pre[acc_pri][31:0];
            K_WR:  m_acc[acc_pri][31:0] = din;
            K_CP:  m_acc[acc_sec] = pre[acc_pri];
            K_XRD: m_dout = {pre[acc_pri | 2'd1][47:32], pre[acc_pri & 2'd2][47:32]};
            K_XWR: begin
                m_acc[acc_pri & 2'd2][47:32] = din[15:0];
                m_acc[acc_pri | 2'd1][47:32] = din[31:16];
            end
            K_ST:  m_ovf = din[0];
            default: ;
        endcase
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 4; i++) m_acc[i] = '0;
            m_dout = '0; m_done = 0; m_ovf = 0;
        end else model_step();
        @(negedge clk);
        n_cmp++;
        if (dout !== m_dout || done !== m_done || ovf !== m_ovf) begin
            n_bad++;
            $display("FAIL %s: actual dout=%h done=%b ovf=%b expected dout=%h done=%b ovf=%b",
                     tag, dout, done, ovf, m_dout, m_done, m_ovf);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [1:0] p, input logic [1:0] s,
                         input logic [31:0] d, input string tag);
        start = 1; cmd = c; acc_pri = p; acc_sec = s; din = d;
        cycle(tag);
        start = 0;
    endtask

    task automatic mac(input logic [31:0] x, input logic [31:0] y, input logic lng,
                       input logic xu, input logic yu, input logic [1:0] sc,
                       input logic sb, input logic [1:0] dm, input logic [1:0] p,
                       input logic [1:0] s, input string tag);
        opx = x; opy = y; long_mode = lng; x_upper = xu; y_upper = yu;
        scale = sc; subtract = sb; dual_mode = dm;
        issue(K_MAC, p, s, '0, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 4; i++) issue(K_RD, 2'(i), 2'd0, '0, tag);
        issue(K_XRD, 2'd0, 2'd0, '0, tag);
        issue(K_XRD, 2'd2, 2'd0, '0, tag);
    endtask

    initial begin
        repeat (3) cycle("R1");
        rst = 0;
        cycle("R1");
        read_all("R1");

        // R2: long signed add and subtract
        issue(K_WR, 2'd0, 2'd0, 32'd100, "R9");
        mac(32'd7, 32'hFFFF_FFFD, 1, 0, 0, 2'd0, 0, 2'd0, 2'd0, 2'd0, "R2");
        mac(32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 0, 2'd0, 1, 2'd0, 2'd1, 2'd0, "R2");
        read_all("R2");

        // R3 / R4: all four half-select combinations with negative halves
        for (int k = 0; k < 4; k++)
            mac(32'h0005_FFFE, 32'hFFFD_0003, 0, k[1], k[0], 2'd0, 0, 2'd0,
                2'(k), 2'd0, "R3");
        read_all("R4");

        // R5: scale codes on an odd negative product
        for (int k = 0; k < 4; k++) begin
            issue(K_XWR, 2'(k), 2'd0, 32'd0, "R5");
            issue(K_WR, 2'(k), 2'd0, 32'd0, "R5");
            mac(32'hFFFF_FFF9, 32'd3, 1, 0, 0, 2'(k), 0, 2'd0, 2'(k), 2'd0, "R5");
        end
        read_all("R5");

        // R6: dual modes, independent of the primary direction
        for (int k = 0; k < 4; k++)
            mac(32'd11, 32'd13, 1, 0, 0, 2'd0, k[0], 2'(k), 2'd0, 2'd2, "R6");
        read_all("R6");

        // R7: same target, secondary subtract must win over primary add
        issue(K_WR, 2'd1, 2'd0, 32'd1000, "R7");
        mac(32'd5, 32'd6, 1, 0, 0, 2'd0, 0, 2'd3, 2'd1, 2'd1, "R7");
        read_all("R7");

        // R8: drive acc0 to the top of the range, cross it, wrap, sticky flag
        issue(K_XWR, 2'd0, 2'd0, 32'h0000_7FFF, "R10");
        issue(K_WR, 2'd0, 2'd0, 32'hFFFF_FFFF, "R8");
        mac(32'd1, 32'd1, 1, 0, 0, 2'd0, 0, 2'd0, 2'd0, 2'd0, "R8");
        read_all("R8");
        issue(K_ST, 2'd0, 2'd0, 32'd0, "R8");
        issue(K_WR, 2'd0, 2'd0, 32'hFFFF_FFFF, "R8");
        issue(K_XWR, 2'd0, 2'd0, 32'h0000_7FFF, "R8");
        mac(32'd1, 32'd1, 1, 0, 0, 2'd0, 1, 2'd1, 2'd0, 2'd0, "R8");
        read_all("R7");
        issue(K_NOP, 2'd0, 2'd0, '0, "R8");
        issue(K_ST, 2'd0, 2'd0, 32'd1, "R8");
        issue(K_ST, 2'd0, 2'd0, 32'd0, "R8");

        // R9 / R10: copy and extension layout
        issue(K_XWR, 2'd2, 2'd0, 32'hA5A5_1234, "R10");
        issue(K_CP, 2'd3, 2'd0, '0, "R9");
        issue(K_WR, 2'd0, 2'd0, 32'hCAFE_0001, "R9");
        read_all("R10");

        // R11: controls waggle with start low, then everything read back
        for (int k = 0; k < 6; k++) begin
            cmd = 3'(k); acc_pri = 2'(k); acc_sec = 2'(k + 1);
            din = 32'hFFFF_FFFF; opx = 32'h7FFF_FFFF; opy = 32'h7FFF_FFFF;
            dual_mode = 2'd1; scale = 2'd1;
            cycle("R11");
        end
        read_all("R11");

        // mixed run of arbitrary commands
        for (int k = 0; k < 2000; k++) begin
            start = $urandom_range(0, 3) != 0;
            cmd = 3'($urandom); opx = $urandom; opy = $urandom; din = $urandom;
            long_mode = 1'($urandom); x_upper = 1'($urandom); y_upper = 1'($urandom);
            scale = 2'($urandom); subtract = 1'($urandom); dual_mode = 2'($urandom);
            acc_pri = 2'($urandom); acc_sec = 2'($urandom);
            cycle("R11");
        end
        start = 0;
        read_all("R2");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule